// File: doc/BRIEF.md
# Parallel Display Bus Cycle Timer

This block drives the control strobes of an asynchronous parallel display bus in the common 8080 style: one chip-select line per channel, a write strobe, a read strobe and a command/data select line. A host issues one bus cycle at a time over a request/ready handshake. Each request is a command write, a data (parameter) write or a read. The block then plays out the cycle by counting timing ticks from the moment of acceptance. Every strobe edge and the cycle length are taken from packed timing words that belong to the selected channel.

Each channel has three configuration inputs. The first is an edge word that holds the on and off tick of chip select, write strobe and read strobe. The second is a period word that holds the write and read cycle lengths and the tick on which read data is sampled. The third is a mode word that holds a tick-doubling bit and one polarity bit for each line. A channel select input picks which channel the next cycle uses. During a read, the block samples the input data bus once and presents the captured value together with a one-clock valid pulse. All bus pins are registered, so they change only on clock edges.

Top module: `pbt_top`

## Requirements
- R1: From the first clock edge after reset is released, and with no cycle started: every chip-select, write-strobe and read-strobe pin sits at its inactive level, the command/data line sits at its data level, bus_oe is 0, rd_valid is 0 and rd_data is 0.
- R2: chan_sel value 1 selects channel 0 and value 2 selects channel 1. With value 0 or 3, req_ready stays 0 and req_valid starts no cycle, so every pin stays idle.
- R3: A request is accepted on a clock edge where both req_valid and req_ready are 1. From that edge on, req_ready stays 0 for exactly L×G clocks. L is the write length (period word bits 5:0) for op 0 and op 1, or the read length (bits 11:6) for op 2. G is the tick size in clocks.
- R4: Tick t is the t-th tick after acceptance, counted from 0. The active channel's chip select is asserted for ticks t with cs_on ≤ t < cs_off, where cs_on is edge word bits 3:0 and cs_off is bits 9:4. A channel that is not in use keeps its chip select inactive.
- R5: In a write cycle (op 0 = command, op 1 = data), the write strobe is asserted for wr_on ≤ t < wr_off, where wr_on is edge bits 13:10 and wr_off is bits 19:14. The read strobe stays inactive.
- R6: In a read cycle (op 2), the read strobe is asserted for rd_on ≤ t < rd_off, where rd_on is edge bits 23:20 and rd_off is bits 29:24. The write strobe stays inactive and bus_oe stays 0.
- R7: During a command cycle, bus_dc is at its command level. It is at its data level during data and read cycles and while idle.
- R8: When mode bit 0 of the active channel is 1, each tick lasts two clocks (G = 2). Otherwise a tick lasts one clock (G = 1).
- R9: In a read cycle, bus_din is sampled on the first clock of tick A, where A is period word bits 17:12. rd_data shows the sampled value from the next clock on and holds it until the next capture. rd_valid is 1 for exactly that one clock.
- R10: Mode bits 4, 3 and 2 give the active level of chip select, write strobe and read strobe: 1 means active high and 0 means active low. Mode bit 1 is the level of bus_dc in a command cycle; the data level is its inverse. The channel of the most recently accepted cycle, channel 0 after reset, sets the levels of the shared lines.
- R11: During every clock of a write cycle, bus_oe is 1 and bus_dout carries the req_wdata value that was accepted with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_sel | input | 2 | Channel select: 1 = channel 0, 2 = channel 1, other values = none |
| chan_edges | input | 2×30 | Per-channel strobe edge word |
| chan_period | input | 2×18 | Per-channel period word: write length, read length, sample tick |
| chan_mode | input | 2×5 | Per-channel tick doubling and line polarities |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 command write, 1 data write, 2 read |
| req_wdata | input | 16 | Write value |
| req_ready | output | 1 | Block can accept a request this clock |
| bus_cs | output | 2 | Chip-select pins, one per channel |
| bus_wr | output | 1 | Write strobe pin |
| bus_rd | output | 1 | Read strobe pin |
| bus_dc | output | 1 | Command/data select pin |
| bus_dout | output | 16 | Outgoing data bus |
| bus_oe | output | 1 | Output enable for the data bus |
| bus_din | input | 16 | Incoming data bus |
| rd_data | output | 16 | Last captured read value |
| rd_valid | output | 1 | One-clock pulse when rd_data is updated |

## Verification
The assertions check these properties on every clock:
- an accepted request starts a cycle at tick zero;
- at most one chip select is active;
- the read strobe and bus_oe are never active together;
- the tick counter holds during the first half of a doubled tick;
- rd_valid never lasts two clocks;
- an unselected channel never starts a cycle.

The exact positions of strobe edges, the cycle lengths, the polarity choices and which bus_din value a read captures depend on the programmed words. Only the bench shows those: its reference model recomputes every pin from elapsed clocks since acceptance and compares it on each clock, across both channels, all three operations and both tick sizes.

// File: rtl/pbt_pkg.sv
package pbt_pkg;

    localparam int ON_W  = 4;
    localparam int OFF_W = 6;
    localparam int TW    = 6;

    typedef enum logic [1:0] {
        OP_CMD  = 2'd0,
        OP_DATA = 2'd1,
        OP_READ = 2'd2,
        OP_RSVD = 2'd3
    } op_e;

    // Edge word: field order fixed by the register that feeds it.
    typedef struct packed {
        logic [OFF_W-1:0] rd_off;
        logic [ON_W-1:0]  rd_on;
        logic [OFF_W-1:0] wr_off;
        logic [ON_W-1:0]  wr_on;
        logic [OFF_W-1:0] cs_off;
        logic [ON_W-1:0]  cs_on;
    } edges_t;

    typedef struct packed {
        logic [TW-1:0] sample;
        logic [TW-1:0] rd_len;
        logic [TW-1:0] wr_len;
    } period_t;

    typedef struct packed {
        logic cs_hi;
        logic wr_hi;
        logic rd_hi;
        logic dc_hi;
        logic dbl;
    } mode_t;

    localparam int EDGE_W = $bits(edges_t);
    localparam int PER_W  = $bits(period_t);
    localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/pbt_window.sv
module pbt_window
    import pbt_pkg::*;
(
    input  logic             en,
    input  logic [TW-1:0]    tick,
    input  logic [ON_W-1:0]  on_t,
    input  logic [OFF_W-1:0] off_t,
    input  logic             act_hi,
    output logic             pin
);
    logic active;
    always_comb begin
        active = en && (tick >= TW'(on_t)) && (tick < TW'(off_t));
        pin    = act_hi ? active : !active;
    end
endmodule

// File: rtl/pbt_chan_mux.sv
module pbt_chan_mux
    import pbt_pkg::*;
#(
    parameter int NCH = 2,
    parameter int CW  = 1
) (
    input  logic [CW-1:0]             idx,
    input  logic [NCH-1:0][EDGE_W-1:0] edges,
    input  logic [NCH-1:0][PER_W-1:0]  periods,
    input  logic [NCH-1:0][MODE_W-1:0] modes,
    output edges_t                    sel_e,
    output period_t                   sel_p,
    output mode_t                     sel_m
);
    always_comb begin
        sel_e = edges_t'(edges[idx]);
        sel_p = period_t'(periods[idx]);
        sel_m = mode_t'(modes[idx]);
    end
endmodule

// File: rtl/pbt_top.sv
module pbt_top
    import pbt_pkg::*;
#(
    parameter int NCH = 2,
    parameter int DW  = 16,
    localparam int SW = $clog2(NCH + 1),
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SW-1:0]             chan_sel,
    input  logic [NCH-1:0][EDGE_W-1:0] chan_edges,
    input  logic [NCH-1:0][PER_W-1:0]  chan_period,
    input  logic [NCH-1:0][MODE_W-1:0] chan_mode,
    input  logic                      req_valid,
    input  logic [1:0]                req_op,
    input  logic [DW-1:0]             req_wdata,
    output logic                      req_ready,
    output logic [NCH-1:0]            bus_cs,
    output logic                      bus_wr,
    output logic                      bus_rd,
    output logic                      bus_dc,
    output logic [DW-1:0]             bus_dout,
    output logic                      bus_oe,
    input  logic [DW-1:0]             bus_din,
    output logic [DW-1:0]             rd_data,
    output logic                      rd_valid
);

    typedef struct packed {
        logic          busy;
        logic [TW-1:0] tick;
        logic          half;
        op_e           op;
        logic [CW-1:0] ch;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          rvalid;
    } state_t;

    typedef struct packed {
        logic [NCH-1:0] cs;
        logic           wr;
        logic           rd;
        logic           dc;
        logic           oe;
    } pins_t;

    state_t  st_q, st_d;
    pins_t   pin_q, pin_d;
    edges_t  cur_e, nxt_e;
    period_t cur_p, nxt_p;
    mode_t   cur_m, nxt_m;
    logic    sel_ok;
    logic    step;
    logic [TW-1:0] cur_len;

    // Timing set of the cycle in progress, and of the cycle seen next clock.
    pbt_chan_mux #(.NCH(NCH), .CW(CW)) u_mux_cur (
        .idx(st_q.ch), .edges(chan_edges), .periods(chan_period), .modes(chan_mode),
        .sel_e(cur_e), .sel_p(cur_p), .sel_m(cur_m)
    );
    pbt_chan_mux #(.NCH(NCH), .CW(CW)) u_mux_nxt (
        .idx(st_d.ch), .edges(chan_edges), .periods(chan_period), .modes(chan_mode),
        .sel_e(nxt_e), .sel_p(nxt_p), .sel_m(nxt_m)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rvalid = 1'b0;
        sel_ok   = (chan_sel != '0) && (chan_sel <= SW'(NCH));
        req_ready = !st_q.busy && sel_ok;
        cur_len  = (st_q.op == OP_READ) ? cur_p.rd_len : cur_p.wr_len;
        step     = !cur_m.dbl || st_q.half;
        if (st_q.busy) begin
            if (st_q.op == OP_READ && st_q.tick == cur_p.sample && !st_q.half) begin
                st_d.rdata  = bus_din;
                st_d.rvalid = 1'b1;
            end
            st_d.half = cur_m.dbl && !st_q.half;
            if (step) begin
                if (st_q.tick == cur_len - 1'b1) begin
                    st_d.busy = 1'b0;
                    st_d.tick = '0;
                end else begin
                    st_d.tick = st_q.tick + 1'b1;
                end
            end
        end else if (req_valid && sel_ok) begin
            st_d.busy  = 1'b1;
            st_d.tick  = '0;
            st_d.half  = 1'b0;
            st_d.op    = op_e'(req_op);
            st_d.ch    = CW'(chan_sel - 1'b1);
            st_d.wdata = req_wdata;
        end
    end

    // Pin levels for the next clock, decoded from the next state.
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_cs
            edges_t ce;
            mode_t  cm;
            assign ce = edges_t'(chan_edges[c]);
            assign cm = mode_t'(chan_mode[c]);
            pbt_window u_cs (
                .en(st_d.busy && st_d.ch == CW'(c)), .tick(st_d.tick),
                .on_t(ce.cs_on), .off_t(ce.cs_off), .act_hi(cm.cs_hi), .pin(pin_d.cs[c])
            );
        end
    endgenerate

    pbt_window u_wr (
        .en(st_d.busy && st_d.op != OP_READ), .tick(st_d.tick),
        .on_t(nxt_e.wr_on), .off_t(nxt_e.wr_off), .act_hi(nxt_m.wr_hi), .pin(pin_d.wr)
    );
    pbt_window u_rd (
        .en(st_d.busy && st_d.op == OP_READ), .tick(st_d.tick),
        .on_t(nxt_e.rd_on), .off_t(nxt_e.rd_off), .act_hi(nxt_m.rd_hi), .pin(pin_d.rd)
    );

    assign pin_d.dc = (st_d.busy && st_d.op == OP_CMD) ? nxt_m.dc_hi : !nxt_m.dc_hi;
    assign pin_d.oe = st_d.busy && st_d.op != OP_READ;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= '0;
            pin_q <= '0;
        end else begin
            st_q  <= st_d;
            pin_q <= pin_d;
        end
    end

    assign bus_cs   = pin_q.cs;
    assign bus_wr   = pin_q.wr;
    assign bus_rd   = pin_q.rd;
    assign bus_dc   = pin_q.dc;
    assign bus_oe   = pin_q.oe;
    assign bus_dout = st_q.wdata;
    assign rd_data  = st_q.rdata;
    assign rd_valid = st_q.rvalid;

    // ---------------- assertions ----------------
    logic [NCH-1:0] cs_act;
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_csact
            mode_t am;
            assign am        = mode_t'(chan_mode[c]);
            assign cs_act[c] = (bus_cs[c] == am.cs_hi);
        end
    endgenerate

    assert_accept_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (st_q.busy && st_q.tick == '0));

    assert_idle_unselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !sel_ok) |=> !st_q.busy);

    assert_single_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_act));

    assert_no_rd_with_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (bus_rd != cur_m.rd_hi));

    assert_tick_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && cur_m.dbl && !st_q.half) |=> $stable(st_q.tick));

    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: tb/pbt_top_test.sv
module pbt_top_test;
    import pbt_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [1:0]              chan_sel = 2'd0;
    logic [1:0][EDGE_W-1:0]  chan_edges;
    logic [1:0][PER_W-1:0]   chan_period;
    logic [1:0][MODE_W-1:0]  chan_mode;
    logic                    req_valid = 1'b0;
    logic [1:0]              req_op = 2'd0;
    logic [15:0]             req_wdata = 16'h0;
    logic                    req_ready;
    logic [1:0]              bus_cs;
    logic                    bus_wr, bus_rd, bus_dc, bus_oe, rd_valid;
    logic [15:0]             bus_dout, rd_data;
    logic [15:0]             bus_din = 16'h0;

    pbt_top uut (
        .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .chan_edges(chan_edges),
        .chan_period(chan_period), .chan_mode(chan_mode), .req_valid(req_valid),
        .req_op(req_op), .req_wdata(req_wdata), .req_ready(req_ready),
        .bus_cs(bus_cs), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_dc(bus_dc),
        .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit cmp_on = 0;
    bit done = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h @%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // ---------------- reference model ----------------
    edges_t  e0, e1;
    period_t p0, p1;
    mode_t   o0, o1;
    assign chan_edges[0]  = e0;
    assign chan_edges[1]  = e1;
    assign chan_period[0] = p0;
    assign chan_period[1] = p1;
    assign chan_mode[0]   = o0;
    assign chan_mode[1]   = o1;

    bit m_busy;
    int m_el, m_len, m_g, m_op, m_ch, m_acc;
    logic [15:0] m_wd, x_rd;
    logic [1:0] x_cs;
    logic x_wr, x_rd_pin, x_dc, x_oe, x_rv;

    function automatic logic win(input bit en, input int t, input int on, input int off, input logic hi);
        logic a;
        a = en && t >= on && t < off;
        return hi ? a : !a;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_el = 0; m_len = 1; m_g = 1; m_op = 0; m_ch = 0; m_acc = 0;
            m_wd = 0; x_rd = 0; x_rv = 0;
        end else begin
            edges_t  ee;
            period_t pp;
            mode_t   mm;
            int t;
            x_rv = 0;
            if (m_busy) begin
                if (m_op == 2 && m_el == m_acc * m_g) begin
                    x_rd = bus_din;
                    x_rv = 1;
                end
                m_el++;
                if (m_el == m_len * m_g) m_busy = 0;
            end else if (req_valid && (chan_sel == 2'd1 || chan_sel == 2'd2)) begin
                m_busy = 1; m_el = 0; m_ch = int'(chan_sel) - 1; m_op = int'(req_op); m_wd = req_wdata;
                pp = (m_ch == 0) ? p0 : p1;
                mm = (m_ch == 0) ? o0 : o1;
                m_g = mm.dbl ? 2 : 1;
                m_len = (m_op == 2) ? int'(pp.rd_len) : int'(pp.wr_len);
                m_acc = int'(pp.sample);
            end
            t  = m_el / m_g;
            x_cs[0] = win(m_busy && m_ch == 0, t, e0.cs_on, e0.cs_off, o0.cs_hi);
            x_cs[1] = win(m_busy && m_ch == 1, t, e1.cs_on, e1.cs_off, o1.cs_hi);
            ee = (m_ch == 0) ? e0 : e1;
            mm = (m_ch == 0) ? o0 : o1;
            x_wr     = win(m_busy && m_op != 2, t, ee.wr_on, ee.wr_off, mm.wr_hi);
            x_rd_pin = win(m_busy && m_op == 2, t, ee.rd_on, ee.rd_off, mm.rd_hi);
            x_dc     = (m_busy && m_op == 0) ? mm.dc_hi : !mm.dc_hi;
            x_oe     = m_busy && m_op != 2;
            cmp_on   = 1;
        end
    end

    // Compare every clock, mid-cycle.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R4/R10", "bus_cs", 32'(bus_cs), 32'(x_cs));
            chk("R5", "bus_wr", 32'(bus_wr), 32'(x_wr));
            chk("R6", "bus_rd", 32'(bus_rd), 32'(x_rd_pin));
            chk("R7", "bus_dc", 32'(bus_dc), 32'(x_dc));
            chk("R11", "bus_oe", 32'(bus_oe), 32'(x_oe));
            if (x_oe) chk("R11", "bus_dout", 32'(bus_dout), 32'(m_wd));
            chk("R9", "rd_valid", 32'(rd_valid), 32'(x_rv));
            chk("R9", "rd_data", 32'(rd_data), 32'(x_rd));
            chk("R3", "req_ready", 32'(req_ready),
                32'(!m_busy && (chan_sel == 2'd1 || chan_sel == 2'd2)));
        end
    end

    // Changing incoming bus value, so the capture tick matters.
    initial begin
        forever begin
            @(posedge clk);
            #1 bus_din = bus_din + 16'h0137;
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input logic [1:0] op, input logic [15:0] d, output int low_clks);
        req_valid = 1; req_op = op; req_wdata = d;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk);
        #1 req_valid = 0;
        low_clks = 0;
        forever begin
            @(negedge clk);
            if (req_ready) break;
            low_clks++;
        end
        @(posedge clk);
        #1;
    endtask

    initial begin
        int lc;
        e0 = '{rd_off: 6'd6, rd_on: 4'd2, wr_off: 6'd5, wr_on: 4'd2, cs_off: 6'd7, cs_on: 4'd1};
        p0 = '{sample: 6'd4, rd_len: 6'd9, wr_len: 6'd8};
        o0 = '{cs_hi: 1'b0, wr_hi: 1'b0, rd_hi: 1'b0, dc_hi: 1'b0, dbl: 1'b0};
        e1 = '{rd_off: 6'd4, rd_on: 4'd1, wr_off: 6'd3, wr_on: 4'd1, cs_off: 6'd4, cs_on: 4'd0};
        p1 = '{sample: 6'd3, rd_len: 6'd6, wr_len: 6'd5};
        o1 = '{cs_hi: 1'b1, wr_hi: 1'b0, rd_hi: 1'b1, dc_hi: 1'b1, dbl: 1'b1};
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk);
        @(negedge clk);
        // R1: idle levels after reset (channel 0 low-active, channel 1 high-active cs)
        chk("R1", "cs idle", 32'(bus_cs), 32'h1);
        chk("R1", "wr idle", 32'(bus_wr), 32'h1);
        chk("R1", "rd idle", 32'(bus_rd), 32'h1);
        chk("R1", "dc data level", 32'(bus_dc), 32'h1);
        chk("R1", "oe/valid/data", {bus_oe, rd_valid, rd_data}, 32'h0);

        // R2: no channel selected -> no cycle
        @(posedge clk); #1 req_valid = 1; req_op = 2'd1; req_wdata = 16'hDEAD;
        repeat (4) begin
            @(negedge clk);
            chk("R2", "ready with sel 0", 32'(req_ready), 32'h0);
            chk("R2", "oe with sel 0", 32'(bus_oe), 32'h0);
        end
        @(posedge clk); #1 chan_sel = 2'd3;
        repeat (4) begin
            @(negedge clk);
            chk("R2", "ready with sel 3", 32'(req_ready), 32'h0);
            chk("R2", "cs with sel 3", 32'(bus_cs), 32'h1);
        end
        @(posedge clk); #1 req_valid = 0; chan_sel = 2'd1;

        // Channel 0, single-clock ticks
        send(2'd0, 16'h00A5, lc); chk("R3", "cmd write busy clocks", lc, 8);
        send(2'd1, 16'h1234, lc); chk("R3", "data write busy clocks", lc, 8);
        send(2'd2, 16'h0000, lc); chk("R3", "read busy clocks", lc, 9);
        send(2'd1, 16'hBEEF, lc);

        // Channel 1, doubled ticks and inverted polarities
        @(posedge clk); #1 chan_sel = 2'd2;
        send(2'd2, 16'h0000, lc); chk("R8", "doubled read busy clocks", lc, 12);
        send(2'd0, 16'h5A5A, lc); chk("R8", "doubled cmd busy clocks", lc, 10);
        send(2'd1, 16'hC3C3, lc); chk("R10", "doubled data busy clocks", lc, 10);
        send(2'd2, 16'h0000, lc);

        // Back to channel 0 with single ticks again
        @(posedge clk); #1 chan_sel = 2'd1;
        send(2'd2, 16'h0000, lc);
        send(2'd0, 16'h0077, lc);
        repeat (5) @(posedge clk);
        #1 finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule